// File: doc/BRIEF.md
# Reset and Low-Power State Controller

This block sits beside a small 8-bit processor core and decides when that core is held in reset, when its clock runs, and when the oscillator may be shut off. It runs from the raw oscillator clock. A toggle flop halves that clock to form the internal phase, and the phase is handed out as clock enables. Because only one edge of the raw clock is used, the duty cycle of the incoming clock does not matter.

The external reset pin counts only after it has been sampled high on a fixed number of consecutive oscillator edges: 24 by default, which is two machine cycles. Two request bits from the core's power-control register select the low-power states. The idle state stops the CPU clock and keeps the peripheral clock running. An enabled interrupt or a reset ends it. The power-down state stops everything and drops the oscillator enable. Only a qualified reset ends it. A low-power state begins once the core signals that the instruction which set the request bit has finished. When a state ends, the block sends a one-cycle clear strobe for the matching request bit back to the register.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: `clk_phase` is 0 in the first cycle after block reset and inverts on every rising edge of `clk_osc` after that.
- R2: `core_rst` rises on the edge where `rst_pin` is sampled high for the QUAL_CYCLES-th consecutive time (24 by default), and not on any earlier edge.
- R3: If `rst_pin` is sampled low before the window completes, the count starts again from zero. A run of 20 high samples, one low sample and 20 more high samples gives no reset.
- R4: Once `core_rst` is asserted, it stays asserted while `rst_pin` is sampled high. It falls on the first edge at which `rst_pin` is sampled low.
- R5: In the run state, with `core_rst` low, `instr_done` high and only `req_idle` high, the block enters idle at that edge. In idle, `cpu_clk_en` stays 0, `per_clk_en` follows `clk_phase`, and `osc_en` stays 1.
- R6: In idle, `irq_pending` sampled high returns the block to run at that edge, and `clr_idle` is 1 for exactly the following cycle.
- R7: In idle, a high `core_rst` returns the block to run at the next edge, and `clr_idle` pulses for one cycle.
- R8: In power-down, `osc_en`, `cpu_clk_en` and `per_clk_en` are all 0, and `irq_pending` has no effect.
- R9: Power-down ends only when `core_rst` is high. The block is back in run (`osc_en` = 1) one edge after `core_rst` rises, and `clr_pdown` pulses in that cycle.
- R10: If `req_idle` and `req_pdown` are both high when `instr_done` is sampled, the block enters power-down.
- R11: Request bits sampled while `instr_done` is 0 have no effect: `cpu_clk_en` keeps following `clk_phase`.
- R12: With `rst_n` sampled low, the block goes to run with `core_rst` = 0, `clk_phase` = 0 and `osc_en` = 1, even if a reset was qualified before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Raw oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset of this block |
| rst_pin | input | 1 | External reset pin, active high, already synchronous to `clk_osc` |
| req_idle | input | 1 | Idle request bit from the power-control register |
| req_pdown | input | 1 | Power-down request bit from the power-control register |
| instr_done | input | 1 | Pulse marking the end of the current instruction |
| irq_pending | input | 1 | An enabled interrupt is pending |
| core_rst | output | 1 | Qualified reset to the core, active high |
| clk_phase | output | 1 | Divide-by-two internal clock phase |
| cpu_clk_en | output | 1 | CPU clock enable (phase, gated in idle and power-down) |
| per_clk_en | output | 1 | Peripheral clock enable (phase, gated in power-down) |
| osc_en | output | 1 | Oscillator enable, 0 in power-down |
| clr_idle | output | 1 | One-cycle strobe that clears the idle request bit |
| clr_pdown | output | 1 | One-cycle strobe that clears the power-down request bit |

## Verification
The assertions check the following on every cycle:
- the phase alternates;
- reset is held while the pin is high and released one edge after the pin falls;
- `core_rst` never rises before a run of 24 high samples, which a checker counter tracks;
- power-down ignores interrupts;
- each clear strobe is preceded by a legal wake cause.

The bench scenarios cover the rest:
- the exact edge at which reset qualifies, swept over pin-high lengths from 1 to 30 and across an interrupted run;
- entry into each low-power state, and power-down priority when both bits are set;
- that requests without an instruction boundary are ignored;
- the gating pattern of the two clock enables in each state.

// File: rtl/pwr_rst_pkg.sv
// Shared types for the reset and low-power controller.
// Assumes: nothing beyond IEEE 1800-2017.
package pwr_rst_pkg;
    // Operating state of the core as seen by the controller.
    typedef enum logic [1:0] {
        LP_RUN   = 2'd0,
        LP_IDLE  = 2'd1,
        LP_PDOWN = 2'd2
    } lp_state_t;
endpackage

// File: rtl/pwr_rst_qual.sv
// Reset-pin qualifier. It asserts qual_rst once the pin has been sampled high
// on QUAL_CYCLES consecutive edges. It holds qual_rst while the pin stays high
// and releases it on the first low sample.
// Assumes: pin is already synchronous to clk.
module pwr_rst_qual #(
    parameter int QUAL_CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic qual_rst
);
    localparam int CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

    logic [CW-1:0] hi_cnt;

    // Count consecutive high samples; restart on any low sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt   <= '0;
            qual_rst <= 1'b0;
        end else if (!pin) begin
            hi_cnt   <= '0;
            qual_rst <= 1'b0;
        end else if (hi_cnt == LAST) begin
            qual_rst <= 1'b1;
        end else begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwr_clk_div2.sv
// Divide-by-two phase generator. It uses only the rising edge of the raw
// clock, so the input duty cycle does not matter.
// Assumes: clk is the raw oscillator.
module pwr_clk_div2 (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    // Toggle once per oscillator period.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end
endmodule

// File: rtl/pwr_lp_fsm.sv
// Low-power state machine. It enters idle or power-down at an instruction
// boundary, and power-down wins if both are requested. It leaves idle on an
// interrupt or reset and leaves power-down on reset only. Each exit sends a
// one-cycle clear strobe for the matching request bit.
// Assumes: request bits are levels that stay set until the clear strobe.
module pwr_lp_fsm
    import pwr_rst_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      core_rst,
    input  logic      req_idle,
    input  logic      req_pdown,
    input  logic      instr_done,
    input  logic      irq_pending,
    output lp_state_t state,
    output logic      clr_idle,
    output logic      clr_pdown
);
    lp_state_t nxt;
    logic      nxt_clr_idle;
    logic      nxt_clr_pdown;

    // Next-state and exit-strobe decode.
    always_comb begin
        nxt           = state;
        nxt_clr_idle  = 1'b0;
        nxt_clr_pdown = 1'b0;
        unique case (state)
            LP_RUN: begin
                if (!core_rst && instr_done) begin
                    if (req_pdown)     nxt = LP_PDOWN;
                    else if (req_idle) nxt = LP_IDLE;
                end
            end
            LP_IDLE: begin
                if (core_rst || irq_pending) begin
                    nxt          = LP_RUN;
                    nxt_clr_idle = 1'b1;
                end
            end
            LP_PDOWN: begin
                if (core_rst) begin
                    nxt           = LP_RUN;
                    nxt_clr_pdown = 1'b1;
                end
            end
            default: nxt = LP_RUN;
        endcase
    end

    // State and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= LP_RUN;
            clr_idle  <= 1'b0;
            clr_pdown <= 1'b0;
        end else begin
            state     <= nxt;
            clr_idle  <= nxt_clr_idle;
            clr_pdown <= nxt_clr_pdown;
        end
    end
endmodule

// File: rtl/pwr_rst_ctrl.sv
// Top of the reset and low-power controller. It combines the reset-pin
// qualifier, the divide-by-two phase and the low-power state machine, and
// forms the clock and oscillator enables from them.
// Assumes: all inputs are synchronous to clk_osc. The qualifier is clocked
// even in power-down, where a board-level reset restarts the oscillator.
module pwr_rst_ctrl
    import pwr_rst_pkg::*;
#(
    parameter int QUAL_CYCLES = 24
) (
    input  logic clk_osc,
    input  logic rst_n,
    input  logic rst_pin,
    input  logic req_idle,
    input  logic req_pdown,
    input  logic instr_done,
    input  logic irq_pending,
    output logic core_rst,
    output logic clk_phase,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic osc_en,
    output logic clr_idle,
    output logic clr_pdown
);
    lp_state_t st;

    pwr_rst_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk      (clk_osc),
        .rst_n    (rst_n),
        .pin      (rst_pin),
        .qual_rst (core_rst)
    );

    pwr_clk_div2 u_div (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .phase (clk_phase)
    );

    pwr_lp_fsm u_fsm (
        .clk         (clk_osc),
        .rst_n       (rst_n),
        .core_rst    (core_rst),
        .req_idle    (req_idle),
        .req_pdown   (req_pdown),
        .instr_done  (instr_done),
        .irq_pending (irq_pending),
        .state       (st),
        .clr_idle    (clr_idle),
        .clr_pdown   (clr_pdown)
    );

    // Gate the phase by state: the CPU runs only in run, peripherals stop only in power-down.
    always_comb begin
        cpu_clk_en = clk_phase && (st == LP_RUN);
        per_clk_en = clk_phase && (st != LP_PDOWN);
        osc_en     = (st != LP_PDOWN);
    end
endmodule

// File: rtl/pwr_rst_ctrl_chk.sv
// Property checker for pwr_rst_ctrl. It only observes the top-level ports and
// keeps its own count of consecutive high reset-pin samples.
// Assumes: bound to every instance of pwr_rst_ctrl.
module pwr_rst_ctrl_chk #(
    parameter int QUAL_CYCLES = 24
) (
    input logic clk_osc,
    input logic rst_n,
    input logic rst_pin,
    input logic irq_pending,
    input logic core_rst,
    input logic clk_phase,
    input logic cpu_clk_en,
    input logic per_clk_en,
    input logic osc_en,
    input logic clr_idle,
    input logic clr_pdown
);
    localparam int CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

    logic [CW-1:0] seen_hi;

    // Independent count of consecutive high pin samples, saturating.
    always_ff @(posedge clk_osc) begin
        if (!rst_n)              seen_hi <= '0;
        else if (!rst_pin)       seen_hi <= '0;
        else if (seen_hi != LAST) seen_hi <= seen_hi + 1'b1;
    end

    assert_phase_toggle_R1: assert property (@(posedge clk_osc) disable iff (!rst_n)
        1'b1 |=> (clk_phase != $past(clk_phase)));

    assert_no_early_reset_R2: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (!core_rst && seen_hi < LAST) |=> !core_rst);

    assert_low_pin_no_reset_R3: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !rst_pin |=> !core_rst);

    assert_reset_hold_R4: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (core_rst && rst_pin) |=> core_rst);

    assert_pdown_gates_R8: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !osc_en |-> (!cpu_clk_en && !per_clk_en));

    assert_pdown_ignores_irq_R8: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (!osc_en && !core_rst && irq_pending) |=> !osc_en);

    assert_pdown_wake_cause_R9: assert property (@(posedge clk_osc) disable iff (!rst_n)
        clr_pdown |-> ($past(core_rst) && $past(!osc_en) && osc_en));

    assert_idle_wake_cause_R6: assert property (@(posedge clk_osc) disable iff (!rst_n)
        clr_idle |-> ($past(irq_pending) || $past(core_rst)));

    assert_one_strobe_R7: assert property (@(posedge clk_osc) disable iff (!rst_n)
        $onehot0({clr_idle, clr_pdown}));
endmodule

bind pwr_rst_ctrl pwr_rst_ctrl_chk #(.QUAL_CYCLES(QUAL_CYCLES)) u_chk (
    .clk_osc     (clk_osc),
    .rst_n       (rst_n),
    .rst_pin     (rst_pin),
    .irq_pending (irq_pending),
    .core_rst    (core_rst),
    .clk_phase   (clk_phase),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .osc_en      (osc_en),
    .clr_idle    (clr_idle),
    .clr_pdown   (clr_pdown)
);

// File: tb/sim_pwr_rst_ctrl.sv
// Self-checking bench for pwr_rst_ctrl. Inputs change and outputs are
// sampled on the falling edge of a 250 MHz clock.
module sim_pwr_rst_ctrl;
    localparam int QC = 24;

    logic clk = 1'b0;
    logic rst_n, rst_pin, req_idle, req_pdown, instr_done, irq_pending;
    logic core_rst, clk_phase, cpu_clk_en, per_clk_en, osc_en, clr_idle, clr_pdown;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #2 clk = ~clk;

    pwr_rst_ctrl #(.QUAL_CYCLES(QC)) u0 (
        .clk_osc(clk), .rst_n(rst_n), .rst_pin(rst_pin), .req_idle(req_idle),
        .req_pdown(req_pdown), .instr_done(instr_done), .irq_pending(irq_pending),
        .core_rst(core_rst), .clk_phase(clk_phase), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .osc_en(osc_en), .clr_idle(clr_idle),
        .clr_pdown(clr_pdown)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Hold the pin high for QC edges and then one more edge; expect a return to run.
    task automatic pin_reset_release();
        rst_pin = 1'b1;
        repeat (QC) step();
        chk("R4 qualified", core_rst, 1'b1);
        rst_pin = 1'b0;
        step();
        chk("R4 release", core_rst, 1'b0);
    endtask

    initial begin
        int hi;
        rst_n = 1'b0; rst_pin = 1'b0; req_idle = 1'b0; req_pdown = 1'b0;
        instr_done = 1'b0; irq_pending = 1'b0;
        step(); step();
        chk("R12 phase", clk_phase, 1'b0);
        chk("R12 core_rst", core_rst, 1'b0);
        chk("R12 osc_en", osc_en, 1'b1);
        rst_n = 1'b1;
        step();
        chk("R1 first phase", clk_phase, 1'b1);
        // R1: the phase alternates on every edge.
        for (int i = 0; i < 8; i++) begin
            logic p;
            p = clk_phase;
            step();
            chk("R1 toggle", clk_phase, ~p);
        end
        // R2/R4: sweep the pin-high length from 1 to 30.
        for (int len = 1; len <= 30; len++) begin
            rst_pin = 1'b1;
            for (int k = 1; k <= len; k++) begin
                step();
                chk("R2 qualify edge", core_rst, logic'(k >= QC));
            end
            rst_pin = 1'b0;
            step();
            chk("R4 release", core_rst, 1'b0);
        end
        // R3: an interrupted run restarts the count.
        rst_pin = 1'b1;
        repeat (20) step();
        rst_pin = 1'b0;
        step();
        rst_pin = 1'b1;
        hi = 0;
        for (int k = 1; k <= QC; k++) begin
            step();
            hi++;
            chk("R3 restart", core_rst, logic'(hi >= QC));
        end
        rst_pin = 1'b0;
        step();
        // R12: block reset clears a qualified reset.
        rst_pin = 1'b1;
        repeat (QC) step();
        chk("R12 pre", core_rst, 1'b1);
        rst_n = 1'b0;
        step();
        chk("R12 clears core_rst", core_rst, 1'b0);
        rst_pin = 1'b0; rst_n = 1'b1;
        step();
        // R11: requests without an instruction boundary are ignored.
        req_idle = 1'b1; req_pdown = 1'b1;
        begin
            int ones = 0;
            for (int i = 0; i < 6; i++) begin step(); ones += int'(cpu_clk_en); end
            chk("R11 cpu runs", logic'(ones == 3), 1'b1);
            chk("R11 osc on", osc_en, 1'b1);
        end
        req_pdown = 1'b0;
        // R5: enter idle.
        instr_done = 1'b1;
        step();
        instr_done = 1'b0;
        chk("R5 osc on", osc_en, 1'b1);
        begin
            int cpu1 = 0, per1 = 0;
            for (int i = 0; i < 4; i++) begin
                step(); cpu1 += int'(cpu_clk_en); per1 += int'(per_clk_en);
            end
            chk("R5 cpu stopped", logic'(cpu1 == 0), 1'b1);
            chk("R5 peripherals run", logic'(per1 == 2), 1'b1);
        end
        // R6: leave idle on an interrupt.
        irq_pending = 1'b1;
        step();
        chk("R6 clr_idle", clr_idle, 1'b1);
        irq_pending = 1'b0; req_idle = 1'b0;
        begin
            int cpu1 = 0;
            for (int i = 0; i < 2; i++) begin
                step(); cpu1 += int'(cpu_clk_en);
                if (i == 0) chk("R6 strobe one cycle", clr_idle, 1'b0);
            end
            chk("R6 cpu resumes", logic'(cpu1 == 1), 1'b1);
        end
        // R7: leave idle on a reset.
        req_idle = 1'b1; instr_done = 1'b1;
        step();
        instr_done = 1'b0;
        rst_pin = 1'b1;
        repeat (QC) step();
        chk("R7 reset seen", core_rst, 1'b1);
        step();
        chk("R7 clr_idle", clr_idle, 1'b1);
        req_idle = 1'b0; rst_pin = 1'b0;
        step();
        chk("R7 strobe ends", clr_idle, 1'b0);
        // R10: both bits set -> power-down wins.
        req_idle = 1'b1; req_pdown = 1'b1; instr_done = 1'b1;
        step();
        instr_done = 1'b0;
        chk("R10 pdown chosen", osc_en, 1'b0);
        // R8: interrupts ignored, everything gated.
        irq_pending = 1'b1;
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R8 osc off", osc_en, 1'b0);
            chk("R8 cpu off", cpu_clk_en, 1'b0);
            chk("R8 per off", per_clk_en, 1'b0);
        end
        chk("R8 no clr", clr_idle | clr_pdown, 1'b0);
        irq_pending = 1'b0;
        // R9: only reset wakes from power-down.
        rst_pin = 1'b1;
        repeat (QC) step();
        chk("R9 still down at reset", osc_en, 1'b0);
        step();
        chk("R9 osc back", osc_en, 1'b1);
        chk("R9 clr_pdown", clr_pdown, 1'b1);
        chk("R9 idle bit untouched", clr_idle, 1'b0);
        req_idle = 1'b0; req_pdown = 1'b0; rst_pin = 1'b0;
        step();
        chk("R9 strobe ends", clr_pdown, 1'b0);
        pin_reset_release();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule